// File: doc/BRIEF.md
# MDIO Management Controller with Change-Detect Scan

This block drives a two-wire management bus (MDC clock, bidirectional MDIO data) toward as many as 32 PHY devices, each with 32 registers of 16 bits. It builds and shifts every read and write frame itself, so the host only supplies an opcode, a device address, a register address and, for writes, the data word. Single operations target one device. Gang operations apply one register access to every device picked by a 32-bit select mask. The data for a gang operation lives in an internal RAM of 32 sixteen-bit entries, one per device address.

In scan mode the controller keeps polling one chosen register on the selected devices. It compares each value it reads with the copy held in the RAM. When a value differs, it sets that device's changed flag, stores the new value and raises the interrupt. The interrupt stays high until the host clears every flag. The host reads and writes the RAM through a 32-bit word port whose upper half reads as zero.

Top module: `mdio_mgmt_ctrl`

## Requirements
- R1: A write frame on `mdio_o` is, in bit order: 32 ones, start bits 0 then 1, opcode 0 then 1, the 5-bit device address MSB first, the 5-bit register address MSB first, turnaround 1 then 0, and the 16 data bits MSB first. A single write (`cmd_op`=1) sends one such frame to `cmd_phy`/`cmd_reg` carrying `cmd_wdata`.
- R2: A read frame carries opcode 1 then 0. `mdio_oe` is low from the first turnaround bit to the end of the frame. The 16 data bits are sampled from `mdio_i` on MDC rising edges. After a single read (`cmd_op`=0), `rd_data` holds the value read once `busy` is low.
- R3: One MDC period lasts 2*(`mdc_half`+1) clock cycles. MDC is low when no frame is in progress. `mdio_o` changes only when MDC falls.
- R4: A command presented while `busy` is low is accepted, and `busy` reads high from the next cycle until the operation ends. A command presented while `busy` is high is ignored.
- R5: A gang write (`cmd_op`=3) sends one write frame to each device whose `dev_mask` bit is set, in ascending address order. Each frame carries that device's RAM entry. Unselected devices receive no frame.
- R6: A gang read (`cmd_op`=2) stores register `cmd_reg` of each selected device into that device's RAM entry. The other entries are left unchanged.
- R7: `ram_rdata` returns `{16'b0, entry[ram_addr]}` without delay. A write through `ram_we` takes effect only while `busy` is low and is ignored while it is high.
- R8: While `scan_en` is high and no command is pending, the controller runs repeated passes that read `scan_reg` from the devices selected by `dev_mask`. A read value that differs from the RAM entry sets bit d of `chg_flags` and overwrites the entry. Equal values leave the flags as they are.
- R9: `irq` is high exactly when any changed flag is set. Writing a one to bit d of `flag_clr` clears flag d on the next cycle.
- R10: After reset, `busy`, `mdc`, `mdio_oe`, `irq` and `chg_flags` are all zero.
- R11: When a command and `scan_en` are both present while idle, the command runs first.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| cmd_valid | input | 1 | Command strobe |
| cmd_op | input | 2 | 0 single read, 1 single write, 2 gang read, 3 gang write |
| cmd_phy | input | 5 | Device address for single operations |
| cmd_reg | input | 5 | Register address |
| cmd_wdata | input | 16 | Write data for a single write |
| dev_mask | input | 32 | Device select for gang and scan operations |
| scan_en | input | 1 | Enables continuous scan passes |
| scan_reg | input | 5 | Register polled during scan |
| mdc_half | input | 8 | MDC half period minus one, in clock cycles |
| ram_we | input | 1 | Host write strobe for the per-device RAM |
| ram_addr | input | 5 | Host RAM entry index |
| ram_wdata | input | 16 | Host RAM write data |
| ram_rdata | output | 32 | Host RAM read word, upper 16 bits zero |
| flag_clr | input | 32 | Write-one-to-clear for the changed flags |
| chg_flags | output | 32 | Per-device changed flags |
| irq | output | 1 | Interrupt, high while any flag is set |
| busy | output | 1 | An operation or scan pass is in progress |
| rd_data | output | 16 | Result of the last single read |
| mdc | output | 1 | Management clock |
| mdio_o | output | 1 | Management data out |
| mdio_oe | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data in |

## Verification
A frame takes 64 MDC periods of 2*(`mdc_half`+1) cycles each. `busy` is high one cycle after a command is accepted and drops one cycle after the last MDC falling edge. At that point `rd_data`, the RAM entries and any new changed flag are already valid. The bench therefore waits for `busy` to fall and then samples on the falling clock edge. Flag clears and host RAM writes are sampled on the falling edge after the rising edge that registers them. The bench PHY model checks frame bits on MDC rising edges and drives read data on MDC falling edges, the same timing the controller uses.

// File: rtl/mdio_mgr_pkg.sv
package mdio_mgr_pkg;
  typedef enum logic [1:0] {
    OP_SRD = 2'd0,
    OP_SWR = 2'd1,
    OP_GRD = 2'd2,
    OP_GWR = 2'd3
  } host_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_WAIT = 2'd2
  } seq_st_e;
endpackage

// File: rtl/mdio_frame_engine.sv
module mdio_frame_engine #(
  parameter int PRE_LEN = 32,
  parameter int AW      = 5,
  parameter int DW      = 16,
  parameter int DIV_W   = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             start,
  input  logic             is_rd,
  input  logic [AW-1:0]    phy,
  input  logic [AW-1:0]    regad,
  input  logic [DW-1:0]    wdata,
  input  logic [DIV_W-1:0] half,
  input  logic             mdio_i,
  output logic             run,
  output logic             done,
  output logic [DW-1:0]    rdata,
  output logic             mdc,
  output logic             mdio_o,
  output logic             mdio_oe
);
  localparam int FRAME_LEN = PRE_LEN + 4 + 2*AW + 2 + DW;
  localparam int SLOT_W    = $clog2(FRAME_LEN);
  localparam logic [SLOT_W-1:0] TA_S   = SLOT_W'(PRE_LEN + 4 + 2*AW);
  localparam logic [SLOT_W-1:0] DAT_S  = SLOT_W'(PRE_LEN + 4 + 2*AW + 2);
  localparam logic [SLOT_W-1:0] LAST_S = SLOT_W'(FRAME_LEN - 1);

  logic                 run_q, run_d, mdc_q, mdc_d, rd_q, rd_d, done_q, done_d;
  logic [DIV_W-1:0]     cnt_q, cnt_d;
  logic [SLOT_W-1:0]    slot_q, slot_d;
  logic [FRAME_LEN-1:0] sh_q, sh_d, frame;
  logic [DW-1:0]        rdat_q, rdat_d;
  logic                 tick;

  assign frame = {{PRE_LEN{1'b1}}, 2'b01, (is_rd ? 2'b10 : 2'b01), phy, regad,
                  2'b10, (is_rd ? {DW{1'b0}} : wdata)};
  assign tick  = (cnt_q >= half);

  always_comb begin
    run_d  = run_q;  mdc_d  = mdc_q;  cnt_d = cnt_q; slot_d = slot_q;
    sh_d   = sh_q;   rd_d   = rd_q;   rdat_d = rdat_q; done_d = 1'b0;
    if (!run_q) begin
      if (start) begin
        run_d = 1'b1; mdc_d = 1'b0; cnt_d = '0; slot_d = '0; sh_d = frame; rd_d = is_rd;
      end
    end else if (tick) begin
      cnt_d = '0;
      if (!mdc_q) begin
        mdc_d = 1'b1;
        if (rd_q && (slot_q >= DAT_S)) rdat_d = {rdat_q[DW-2:0], mdio_i};
      end else begin
        mdc_d = 1'b0;
        if (slot_q == LAST_S) begin
          run_d  = 1'b0;
          done_d = 1'b1;
        end else begin
          slot_d = slot_q + 1'b1;
          sh_d   = {sh_q[FRAME_LEN-2:0], 1'b0};
        end
      end
    end else begin
      cnt_d = cnt_q + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      run_q <= 1'b0; mdc_q <= 1'b0; rd_q <= 1'b0; done_q <= 1'b0;
      cnt_q <= '0; slot_q <= '0; sh_q <= '0; rdat_q <= '0;
    end else begin
      run_q <= run_d; mdc_q <= mdc_d; rd_q <= rd_d; done_q <= done_d;
      cnt_q <= cnt_d; slot_q <= slot_d; sh_q <= sh_d; rdat_q <= rdat_d;
    end
  end

  assign run     = run_q;
  assign done    = done_q;
  assign rdata   = rdat_q;
  assign mdc     = mdc_q;
  assign mdio_o  = run_q & sh_q[FRAME_LEN-1];
  assign mdio_oe = run_q & ~(rd_q & (slot_q >= TA_S));

  // R3: the clock rests low between frames
  assert_mdc_low_idle_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !run_q |-> !mdc_q);
  // R3: data only moves on the falling edge
  assert_mdio_hold_high_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (mdc_q && $past(mdc_q)) |-> $stable(mdio_o));
  // R2: completion is a single-cycle pulse
  assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    done_q |=> !done_q);
endmodule

// File: rtl/mdio_mgr_seq.sv
module mdio_mgr_seq
  import mdio_mgr_pkg::*;
#(
  parameter int AW     = 5,
  parameter int DW     = 16,
  parameter int HOST_W = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [1:0]          cmd_op,
  input  logic [AW-1:0]       cmd_phy,
  input  logic [AW-1:0]       cmd_reg,
  input  logic [DW-1:0]       cmd_wdata,
  input  logic [(1<<AW)-1:0]  dev_mask,
  input  logic                scan_en,
  input  logic [AW-1:0]       scan_reg,
  input  logic                ram_we,
  input  logic [AW-1:0]       ram_addr,
  input  logic [DW-1:0]       ram_wdata,
  output logic [HOST_W-1:0]   ram_rdata,
  input  logic [(1<<AW)-1:0]  flag_clr,
  output logic [(1<<AW)-1:0]  chg_flags,
  output logic                irq,
  output logic                busy,
  output logic [DW-1:0]       rd_data,
  output logic                eng_start,
  output logic                eng_rd,
  output logic [AW-1:0]       eng_phy,
  output logic [AW-1:0]       eng_reg,
  output logic [DW-1:0]       eng_wdata,
  input  logic                eng_run,
  input  logic                eng_done,
  input  logic [DW-1:0]       eng_rdata
);
  localparam int NDEV = 1 << AW;
  localparam logic [AW-1:0] LAST_DEV = AW'(NDEV - 1);

  seq_st_e         st_q, st_d;
  logic [AW-1:0]   ptr_q, ptr_d, rg_q, rg_d;
  logic [NDEV-1:0] mask_q, mask_d, chg_q, chg_d, set_vec;
  logic [1:0]      op_q, op_d;
  logic            scan_q, scan_d;
  logic [DW-1:0]   wd_q, wd_d, rdd_q, rdd_d;
  logic [DW-1:0]   ram_q [NDEV];
  logic            ram_wen;
  logic [AW-1:0]   ram_widx;
  logic [DW-1:0]   ram_wval;

  // op bit0 = write, bit1 = per-mask walk; scan walks as a gang read
  assign eng_rd    = scan_q | ~op_q[0];
  assign eng_phy   = ptr_q;
  assign eng_reg   = rg_q;
  assign eng_wdata = op_q[1] ? ram_q[ptr_q] : wd_q;

  always_comb begin
    st_d = st_q; ptr_d = ptr_q; rg_d = rg_q; mask_d = mask_q; op_d = op_q;
    scan_d = scan_q; wd_d = wd_q; rdd_d = rdd_q;
    eng_start = 1'b0; ram_wen = 1'b0; ram_widx = ram_addr; ram_wval = ram_wdata;
    set_vec = '0;
    unique case (st_q)
      ST_IDLE: begin
        ram_wen = ram_we;
        if (cmd_valid) begin
          op_d = cmd_op; scan_d = 1'b0; rg_d = cmd_reg; wd_d = cmd_wdata; st_d = ST_WALK;
          if (cmd_op[1]) begin
            mask_d = dev_mask; ptr_d = '0;
          end else begin
            mask_d = NDEV'(1) << cmd_phy; ptr_d = cmd_phy;
          end
        end else if (scan_en) begin
          op_d = OP_GRD; scan_d = 1'b1; rg_d = scan_reg; mask_d = dev_mask;
          ptr_d = '0; st_d = ST_WALK;
        end
      end
      ST_WALK: begin
        if (mask_q[ptr_q]) begin
          eng_start = 1'b1;
          st_d      = ST_WAIT;
        end else if (ptr_q == LAST_DEV) begin
          st_d = ST_IDLE;
        end else begin
          ptr_d = ptr_q + 1'b1;
        end
      end
      ST_WAIT: begin
        if (eng_done) begin
          if (eng_rd) begin
            if (op_q[1]) begin
              ram_wen = 1'b1; ram_widx = ptr_q; ram_wval = eng_rdata;
              if (scan_q && (eng_rdata != ram_q[ptr_q])) set_vec[ptr_q] = 1'b1;
            end else begin
              rdd_d = eng_rdata;
            end
          end
          if (!op_q[1] || (ptr_q == LAST_DEV)) begin
            st_d = ST_IDLE;
          end else begin
            ptr_d = ptr_q + 1'b1;
            st_d  = ST_WALK;
          end
        end
      end
      default: st_d = ST_IDLE;
    endcase
    chg_d = (chg_q & ~flag_clr) | set_vec;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ST_IDLE; ptr_q <= '0; rg_q <= '0; mask_q <= '0; op_q <= '0;
      scan_q <= 1'b0; wd_q <= '0; rdd_q <= '0; chg_q <= '0;
    end else begin
      st_q <= st_d; ptr_q <= ptr_d; rg_q <= rg_d; mask_q <= mask_d; op_q <= op_d;
      scan_q <= scan_d; wd_q <= wd_d; rdd_q <= rdd_d; chg_q <= chg_d;
    end
  end

  always_ff @(posedge clk) begin
    if (ram_wen) ram_q[ram_widx] <= ram_wval;
  end

  assign ram_rdata = HOST_W'(ram_q[ram_addr]);
  assign chg_flags = chg_q;
  assign irq       = |chg_q;
  assign busy      = (st_q != ST_IDLE);
  assign rd_data   = rdd_q;

  // R4: no frame is in flight while the controller reports idle
  assert_quiet_when_idle_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !eng_run);
  // R1: a frame is only launched into a free shifter
  assert_start_engine_free_R1: assert property (@(posedge clk) disable iff (!rst_n)
    eng_start |-> !eng_run);
  // R8: a changed flag can only rise at the end of a scan read
  assert_flag_from_scan_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(chg_q & ~$past(chg_q))) |-> ($past(scan_q) && ($past(st_q) == ST_WAIT)));
endmodule

// File: rtl/mdio_mgmt_ctrl.sv
module mdio_mgmt_ctrl #(
  parameter int PRE_LEN = 32,
  parameter int AW      = 5,
  parameter int DW      = 16,
  parameter int DIV_W   = 8,
  parameter int HOST_W  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cmd_valid,
  input  logic [1:0]          cmd_op,
  input  logic [AW-1:0]       cmd_phy,
  input  logic [AW-1:0]       cmd_reg,
  input  logic [DW-1:0]       cmd_wdata,
  input  logic [(1<<AW)-1:0]  dev_mask,
  input  logic                scan_en,
  input  logic [AW-1:0]       scan_reg,
  input  logic [DIV_W-1:0]    mdc_half,
  input  logic                ram_we,
  input  logic [AW-1:0]       ram_addr,
  input  logic [DW-1:0]       ram_wdata,
  output logic [HOST_W-1:0]   ram_rdata,
  input  logic [(1<<AW)-1:0]  flag_clr,
  output logic [(1<<AW)-1:0]  chg_flags,
  output logic                irq,
  output logic                busy,
  output logic [DW-1:0]       rd_data,
  output logic                mdc,
  output logic                mdio_o,
  output logic                mdio_oe,
  input  logic                mdio_i
);
  logic [1:0]    rs_q;
  logic          rst_sync_n;
  logic          eng_start, eng_rd, eng_run, eng_done;
  logic [AW-1:0] eng_phy, eng_reg;
  logic [DW-1:0] eng_wdata, eng_rdata;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rs_q <= 2'b00;
    else        rs_q <= {rs_q[0], 1'b1};
  end
  assign rst_sync_n = rs_q[1];

  mdio_mgr_seq #(.AW(AW), .DW(DW), .HOST_W(HOST_W)) u_seq (
    .clk(clk), .rst_n(rst_sync_n),
    .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_phy(cmd_phy), .cmd_reg(cmd_reg),
    .cmd_wdata(cmd_wdata), .dev_mask(dev_mask), .scan_en(scan_en), .scan_reg(scan_reg),
    .ram_we(ram_we), .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata),
    .flag_clr(flag_clr), .chg_flags(chg_flags), .irq(irq), .busy(busy), .rd_data(rd_data),
    .eng_start(eng_start), .eng_rd(eng_rd), .eng_phy(eng_phy), .eng_reg(eng_reg),
    .eng_wdata(eng_wdata), .eng_run(eng_run), .eng_done(eng_done), .eng_rdata(eng_rdata)
  );

  mdio_frame_engine #(.PRE_LEN(PRE_LEN), .AW(AW), .DW(DW), .DIV_W(DIV_W)) u_eng (
    .clk(clk), .rst_n(rst_sync_n), .start(eng_start), .is_rd(eng_rd),
    .phy(eng_phy), .regad(eng_reg), .wdata(eng_wdata), .half(mdc_half),
    .mdio_i(mdio_i), .run(eng_run), .done(eng_done), .rdata(eng_rdata),
    .mdc(mdc), .mdio_o(mdio_o), .mdio_oe(mdio_oe)
  );
endmodule

// File: tb/test_mdio_mgmt_ctrl.sv
module test_mdio_mgmt_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #10 clk = ~clk;

  logic        cmd_valid = 0, scan_en = 0, ram_we = 0, mdio_i = 0;
  logic [1:0]  cmd_op = 0;
  logic [4:0]  cmd_phy = 0, cmd_reg = 0, scan_reg = 0, ram_addr = 0;
  logic [15:0] cmd_wdata = 0, ram_wdata = 0;
  logic [31:0] dev_mask = 0, flag_clr = 0;
  logic [7:0]  mdc_half = 8'd1;
  logic [31:0] ram_rdata, chg_flags;
  logic        irq, busy, mdc, mdio_o, mdio_oe;
  logic [15:0] rd_data;

  mdio_mgmt_ctrl i_mdio_mgmt_ctrl (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op), .cmd_phy(cmd_phy),
    .cmd_reg(cmd_reg), .cmd_wdata(cmd_wdata), .dev_mask(dev_mask), .scan_en(scan_en),
    .scan_reg(scan_reg), .mdc_half(mdc_half), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .ram_rdata(ram_rdata), .flag_clr(flag_clr), .chg_flags(chg_flags),
    .irq(irq), .busy(busy), .rd_data(rd_data), .mdc(mdc), .mdio_o(mdio_o),
    .mdio_oe(mdio_oe), .mdio_i(mdio_i)
  );

  int n_tests = 0, n_fail = 0;
  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // ---------------- PHY model ----------------
  logic [15:0] phy_mem [32][32];
  logic [15:0] ram_exp [32];
  int          bitn = 64;
  logic [63:0] fr;
  logic        cur_rd = 0;
  logic [15:0] rd_val;
  int          nfrm = 0, fmt_err = 0, oe_err = 0, stab_err = 0;
  logic [4:0]  log_phy [256];
  logic [1:0]  log_op  [256];
  logic [15:0] log_dat [256];
  int          cyc = 0, last_rise = 0, mdc_per = 0;
  logic        pmdc = 0, pmo = 0;

  always @(negedge clk) begin
    cyc++;
    if (mdc && pmdc && (mdio_o != pmo)) stab_err++;
    pmdc = mdc; pmo = mdio_o;
  end

  always @(posedge mdio_oe) bitn = 0;

  always @(posedge mdc) begin
    mdc_per   = cyc - last_rise;
    last_rise = cyc;
    if (bitn < 64) begin
      fr[63-bitn] = mdio_o;
      if (cur_rd && bitn >= 46 && mdio_oe) oe_err++;
      if (bitn == 45) begin
        if (fr[63:32] != 32'hFFFF_FFFF || fr[31:30] != 2'b01 ||
            !(fr[29:28] == 2'b01 || fr[29:28] == 2'b10)) fmt_err++;
        cur_rd = (fr[29:28] == 2'b10);
        rd_val = phy_mem[fr[27:23]][fr[22:18]];
      end
      if (bitn == 63) begin
        if (!cur_rd) begin
          if (fr[17:16] != 2'b10) fmt_err++;
          phy_mem[fr[27:23]][fr[22:18]] = fr[15:0];
        end
        log_phy[nfrm % 256] = fr[27:23];
        log_op [nfrm % 256] = fr[29:28];
        log_dat[nfrm % 256] = cur_rd ? rd_val : fr[15:0];
        nfrm++;
      end
      bitn++;
    end
  end

  always @(negedge mdc) begin
    if (cur_rd && bitn >= 48 && bitn <= 63) mdio_i = rd_val[63-bitn];
  end

  // ---------------- helpers ----------------
  function automatic int popc(input logic [31:0] v);
    int c = 0;
    for (int i = 0; i < 32; i++) c += v[i];
    return c;
  endfunction

  task automatic issue(input logic [1:0] op, input logic [4:0] phy, input logic [4:0] rg,
                       input logic [15:0] wd, input logic [31:0] mask);
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_phy = phy; cmd_reg = rg; cmd_wdata = wd; dev_mask = mask;
    @(negedge clk);
    cmd_valid = 0;
  endtask

  task automatic wait_idle();
    @(negedge clk);
    while (busy) @(negedge clk);
  endtask

  task automatic ram_wr(input logic [4:0] a, input logic [15:0] v);
    @(negedge clk);
    ram_we = 1; ram_addr = a; ram_wdata = v;
    @(negedge clk);
    ram_we = 0;
  endtask

  task automatic ram_rd(input logic [4:0] a, output logic [31:0] v);
    ram_addr = a;
    #1;
    v = ram_rdata;
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] v, mask;
    logic [15:0] col [32];
    logic [4:0]  p, r;
    logic [15:0] d;
    int n0, bad;
    void'($urandom(32'd2718));
    for (int i = 0; i < 32; i++)
      for (int j = 0; j < 32; j++) phy_mem[i][j] = 16'($urandom());

    repeat (3) @(negedge clk);
    rst_n = 1;
    repeat (4) @(negedge clk);
    // R10 reset state
    chk(!busy && !mdc && !mdio_oe, "R10 idle outputs", {busy, mdc, mdio_oe}, 0);
    chk(!irq && chg_flags == 0, "R10 flags clear", chg_flags, 0);

    // R1 directed write frame
    issue(2'd1, 5'd5, 5'd3, 16'hA5C3, 0);
    chk(busy, "R4 busy after accept", busy, 1);
    wait_idle();
    chk(phy_mem[5][3] == 16'hA5C3, "R1 write data at phy", phy_mem[5][3], 16'hA5C3);
    chk(log_op[(nfrm-1)%256] == 2'b01 && log_phy[(nfrm-1)%256] == 5'd5,
        "R1 write opcode and address", {log_op[(nfrm-1)%256], log_phy[(nfrm-1)%256]}, {2'b01, 5'd5});
    chk(mdc_per == 4, "R3 mdc period half=1", mdc_per, 4);

    // R3 other divisor
    mdc_half = 8'd2;
    issue(2'd0, 5'd9, 5'd1, 0, 0);
    wait_idle();
    chk(mdc_per == 6, "R3 mdc period half=2", mdc_per, 6);
    chk(rd_data == phy_mem[9][1], "R2 read with half=2", rd_data, phy_mem[9][1]);
    mdc_half = 8'd1;

    // R4 command while busy is ignored
    d = phy_mem[17][4];
    n0 = nfrm;
    issue(2'd1, 5'd11, 5'd2, 16'h1357, 0);
    repeat (10) @(negedge clk);
    issue(2'd1, 5'd17, 5'd4, ~d, 0);
    wait_idle();
    chk(phy_mem[17][4] == d, "R4 busy command ignored", phy_mem[17][4], d);
    chk(nfrm - n0 == 1, "R4 single frame count", nfrm - n0, 1);

    // R1/R2 random single operations
    for (int k = 0; k < 8; k++) begin
      p = 5'($urandom()); r = 5'($urandom()); d = 16'($urandom());
      if ($urandom() % 2 == 0) begin
        issue(2'd1, p, r, d, 0);
        wait_idle();
        chk(phy_mem[p][r] == d, "R1 random write", phy_mem[p][r], d);
      end else begin
        issue(2'd0, p, r, 0, 0);
        wait_idle();
        chk(rd_data == phy_mem[p][r], "R2 random read", rd_data, phy_mem[p][r]);
      end
    end

    // R7 host RAM port
    for (int i = 0; i < 32; i++) begin
      ram_exp[i] = 16'($urandom());
      ram_wr(5'(i), ram_exp[i]);
    end
    @(negedge clk);
    bad = 0;
    for (int i = 0; i < 32; i++) begin
      ram_rd(5'(i), v);
      if (v != {16'h0, ram_exp[i]}) bad++;
    end
    chk(bad == 0, "R7 ram readback zero-extended", bad, 0);
    issue(2'd0, 5'd2, 5'd2, 0, 0);
    ram_wr(5'd7, ~ram_exp[7]);
    wait_idle();
    ram_rd(5'd7, v);
    chk(v == {16'h0, ram_exp[7]}, "R7 ram write ignored while busy", v, {16'h0, ram_exp[7]});

    // R5 gang write
    mask = $urandom() | 32'h0000_0001;
    r = 5'd6;
    for (int i = 0; i < 32; i++) col[i] = phy_mem[i][r];
    n0 = nfrm;
    issue(2'd3, 0, r, 0, mask);
    wait_idle();
    bad = 0;
    for (int i = 0; i < 32; i++)
      if (phy_mem[i][r] != (mask[i] ? ram_exp[i] : col[i])) bad++;
    chk(bad == 0, "R5 gang write data per device", bad, 0);
    chk(nfrm - n0 == popc(mask), "R5 gang write frame count", nfrm - n0, popc(mask));
    bad = 0;
    for (int k = n0 + 1; k < nfrm; k++)
      if (log_phy[k%256] <= log_phy[(k-1)%256]) bad++;
    chk(bad == 0, "R5 ascending device order", bad, 0);

    // R6 gang read
    mask = ($urandom() & 32'h0F0F_0F0F) | 32'h0000_0008;
    r = 5'd1;
    issue(2'd2, 0, r, 0, mask);
    wait_idle();
    bad = 0;
    for (int i = 0; i < 32; i++) begin
      if (mask[i]) ram_exp[i] = phy_mem[i][r];
      ram_rd(5'(i), v);
      if (v[15:0] != ram_exp[i]) bad++;
    end
    chk(bad == 0, "R6 gang read stores selected only", bad, 0);
    chk(!irq, "R8 gang read raises no flag", irq, 0);

    // R8 scan detects a change on a selected device only
    phy_mem[3][r]  = phy_mem[3][r] ^ 16'h0040;
    phy_mem[20][r] = phy_mem[20][r] ^ 16'h0001;
    @(negedge clk);
    scan_reg = r; dev_mask = mask; scan_en = 1;
    for (int t = 0; t < 20000 && !irq; t++) @(negedge clk);
    scan_en = 0;
    wait_idle();
    chk(chg_flags == 32'h0000_0008, "R8 changed flag for device 3", chg_flags, 32'h8);
    chk(irq, "R9 irq with flag set", irq, 1);
    ram_rd(5'd3, v);
    chk(v[15:0] == phy_mem[3][r], "R8 ram copy refreshed", v, phy_mem[3][r]);
    ram_rd(5'd20, v);
    chk(v[15:0] == ram_exp[20], "R8 unselected entry kept", v, ram_exp[20]);

    // R9 write-one-to-clear
    @(negedge clk);
    flag_clr = 32'h0000_0008;
    @(negedge clk);
    flag_clr = 0;
    chk(chg_flags == 0 && !irq, "R9 flag cleared", {irq, chg_flags[30:0]}, 0);

    // R8 scan with no change keeps flags clear
    scan_en = 1;
    repeat (5000) @(negedge clk);
    scan_en = 0;
    wait_idle();
    chk(chg_flags == 0 && !irq, "R8 steady scan no flag", chg_flags, 0);

    // R11 command wins over scan start
    n0 = nfrm;
    @(negedge clk);
    scan_en = 1; dev_mask = 0;
    cmd_valid = 1; cmd_op = 2'd1; cmd_phy = 5'd12; cmd_reg = 5'd7; cmd_wdata = 16'h1234;
    @(negedge clk);
    cmd_valid = 0;
    for (int t = 0; t < 2000 && nfrm == n0; t++) @(negedge clk);
    scan_en = 0;
    repeat (40) @(negedge clk);
    wait_idle();
    chk(nfrm - n0 == 1 && log_op[n0%256] == 2'b01 && log_phy[n0%256] == 5'd12,
        "R11 command ran before scan", {log_op[n0%256], log_phy[n0%256]}, {2'b01, 5'd12});
    chk(phy_mem[12][7] == 16'h1234, "R11 command data", phy_mem[12][7], 16'h1234);

    // frame-level monitors
    chk(fmt_err == 0, "R1 frame format errors", fmt_err, 0);
    chk(oe_err == 0, "R2 oe during read data", oe_err, 0);
    chk(stab_err == 0, "R3 mdio moved while mdc high", stab_err, 0);

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule